// File: doc/BRIEF.md
# DMA Destination Address Stepper

This block produces the destination address sequence for one DMA channel and counts the bursts it moves. Two 16-bit configuration registers are reachable over a small register bus: a signed destination step and a transfer size that holds the number of bursts minus one. Each register takes a write only when the channel is stopped and the protection-unlock input is high. A write that fails either condition leaves the register as it was and raises a one-cycle write-error pulse.

A start pulse loads a base address and sets the running status. For each word of a burst, the current destination address is used first. The word-done strobe then adds the step to it, so the step acts as a post-increment or a post-decrement. The register keeps any value written to it. When the step is applied, it is saturated to the range -4096 to +4095, and the address wraps modulo 2^22.

Each burst-done strobe counts one finished burst. When the count passes the stored transfer size, the running status clears and a done pulse is raised for one cycle.

Top module: `dma_dst_stepper`

## Requirements
- R1: After synchronous reset, both configuration registers read 0, and running, done, wr_err and dst_addr are all 0.
- R2: A cfg_wr with cfg_unlock=1 while running=0 stores cfg_wdata into the register that cfg_sel picks (0 = step, 1 = transfer size). cfg_rdata shows the selected register combinationally, so the new value reads back from the cycle after the write edge, and wr_err stays 0.
- R3: A cfg_wr with cfg_unlock=0 leaves both registers unchanged, and wr_err is 1 for exactly the one cycle after that write edge.
- R4: A cfg_wr while running=1 leaves both registers unchanged and pulses wr_err for one cycle, even when cfg_unlock=1.
- R5: A start while running=0 loads base_addr into dst_addr and sets running, both visible after that edge. A start while running=1 changes neither dst_addr nor the burst count.
- R6: While running, each word_done adds the effective step to dst_addr at that edge, and the address shown before the strobe is the one used for the word. A step of 0x0001 adds 1, 0xFFFE subtracts 2, and 0x0000 leaves the address unchanged.
- R7: The step register stores any written value unchanged. A stored value above 0x0FFF (positive) is used as +4095, and a stored value below 0xF000 (negative) is used as -4096.
- R8: dst_addr is 22 bits wide and wraps modulo 2^22 on both overflow and underflow.
- R9: A transfer-size value N gives N+1 bursts. The (N+1)th burst_done while running clears running and raises done for exactly one cycle after that edge. Earlier burst_done strobes leave running at 1.
- R10: While running=0, word_done and burst_done have no effect on dst_addr, running or done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 step, 1 transfer size |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_unlock | input | 1 | Protection unlock, must be 1 for a write to land |
| cfg_rdata | output | 16 | Selected register contents (combinational) |
| wr_err | output | 1 | One-cycle pulse for a rejected write |
| start | input | 1 | Start pulse, loads base_addr |
| base_addr | input | 22 | Base destination address |
| word_done | input | 1 | One word of the burst has been written |
| burst_done | input | 1 | One burst has finished |
| dst_addr | output | 22 | Current destination address |
| running | output | 1 | Channel running status |
| done | output | 1 | One-cycle pulse after the final burst |

## Verification
Every registered result appears one clock edge after the stimulus that caused it: the stored register value, wr_err, the loaded or stepped dst_addr, the clearing of running and the done pulse. cfg_rdata follows cfg_sel in the same cycle. The bench drives each stimulus on a falling edge and holds it through exactly one rising edge. It samples results on the next falling edge, and samples one more falling edge later to confirm that wr_err and done have already dropped.

// File: rtl/dst_step_pkg.sv
// Package: shared constants and the register select encoding for the
// destination stepper. Assumes a 16-bit configuration word.
package dst_step_pkg;

    // Register select values on cfg_sel
    typedef enum logic {
        SEL_STEP = 1'b0,
        SEL_SIZE = 1'b1
    } cfg_sel_e;

    localparam int DEF_REG_W    = 16;
    localparam int DEF_ADDR_W   = 22;
    localparam int DEF_STEP_MAX = 4095;
    localparam int DEF_STEP_MIN = -4096;

endpackage

// File: rtl/dst_cfg_regs.sv
// Module: dst_cfg_regs
// Holds the step and transfer-size registers behind a write gate.
// A write lands only when unlocked and the channel is stopped. Any other
// write leaves both registers alone and pulses wr_err for one cycle.
// Assumes cfg_sel is stable during the cycle cfg_rdata is sampled.
module dst_cfg_regs
    import dst_step_pkg::*;
#(
    parameter int REG_W = DEF_REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             cfg_unlock,
    input  logic             running,
    output logic [REG_W-1:0] step_q,
    output logic [REG_W-1:0] size_q,
    output logic [REG_W-1:0] cfg_rdata,
    output logic             wr_err
);

    logic wr_ok;

    // Decide whether the current write may land
    always_comb begin
        wr_ok = cfg_wr && cfg_unlock && !running;
    end

    // Register update and write-error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            size_q <= '0;
            wr_err <= 1'b0;
        end else begin
            wr_err <= cfg_wr && !wr_ok;
            if (wr_ok) begin
                if (cfg_sel == SEL_SIZE) begin
                    size_q <= cfg_wdata;
                end else begin
                    step_q <= cfg_wdata;
                end
            end
        end
    end

    // Read mux for the selected register
    always_comb begin
        cfg_rdata = (cfg_sel == SEL_SIZE) ? size_q : step_q;
    end

    // R3: a locked write must not alter either register
    p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_unlock) |=> ($stable(step_q) && $stable(size_q)));

    // R4: a write while running must not alter either register
    p_running_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && running) |=> ($stable(step_q) && $stable(size_q) && wr_err));

endmodule

// File: rtl/dst_addr_gen.sv
// Module: dst_addr_gen
// Destination address register. Loads the base on an accepted start and
// adds the saturated signed step on each word strobe while running.
// Assumes ADDR_W is wider than REG_W and REG_W is at most 32.
module dst_addr_gen
    import dst_step_pkg::*;
#(
    parameter int REG_W    = DEF_REG_W,
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int STEP_MAX = DEF_STEP_MAX,
    parameter int STEP_MIN = DEF_STEP_MIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              word_done,
    input  logic              running,
    input  logic [REG_W-1:0]  step_q,
    output logic [ADDR_W-1:0] dst_addr
);

    localparam int EXT_W = 32 - REG_W;

    int                raw_i;
    int                lim_i;
    logic [ADDR_W-1:0] eff_step;

    // Sign-extend the stored step and clamp it to the legal range
    always_comb begin
        raw_i = {{EXT_W{step_q[REG_W-1]}}, step_q};
        if (raw_i > STEP_MAX) begin
            lim_i = STEP_MAX;
        end else if (raw_i < STEP_MIN) begin
            lim_i = STEP_MIN;
        end else begin
            lim_i = raw_i;
        end
        eff_step = ADDR_W'(lim_i);
    end

    // Address load on start, post-step on each word while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_addr <= '0;
        end else if (start && !running) begin
            dst_addr <= base_addr;
        end else if (running && word_done) begin
            dst_addr <= dst_addr + eff_step;
        end
    end

    // R5: an accepted start loads the base address
    p_start_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !running) |=> (dst_addr == $past(base_addr)));

    // R10: while stopped and not starting, the address holds
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start) |=> $stable(dst_addr));

    // R6: with no word strobe, a running channel keeps its address
    p_no_word_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !word_done) |=> $stable(dst_addr));

endmodule

// File: rtl/dst_burst_ctr.sv
// Module: dst_burst_ctr
// Running status and burst counter. An accepted start clears the count
// and sets running. Each burst strobe counts up, and the strobe that
// matches the stored size (bursts minus one) ends the run with a done pulse.
// Assumes the size register cannot change while running.
module dst_burst_ctr
    import dst_step_pkg::*;
#(
    parameter int REG_W = DEF_REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             burst_done,
    input  logic [REG_W-1:0] size_q,
    output logic             running,
    output logic             done
);

    logic [REG_W-1:0] burst_cnt;

    // Run control, burst count and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running   <= 1'b0;
            done      <= 1'b0;
            burst_cnt <= '0;
        end else begin
            done <= 1'b0;
            if (start && !running) begin
                running   <= 1'b1;
                burst_cnt <= '0;
            end else if (running && burst_done) begin
                if (burst_cnt == size_q) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end else begin
                    burst_cnt <= burst_cnt + 1'b1;
                end
            end
        end
    end

    // R9: the count never passes the programmed size during a run
    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (burst_cnt <= size_q));

    // R9: done lasts one cycle and only once the run has ended
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!running && $fell(running)) ##1 !done);

endmodule

// File: rtl/dma_dst_stepper.sv
// Module: dma_dst_stepper
// Top of the destination stepper for one DMA channel: the protected
// configuration registers, the address generator and the burst counter.
// Assumes start, word_done and burst_done are single-cycle strobes.
module dma_dst_stepper
    import dst_step_pkg::*;
#(
    parameter int REG_W    = DEF_REG_W,
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int STEP_MAX = DEF_STEP_MAX,
    parameter int STEP_MIN = DEF_STEP_MIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              cfg_unlock,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic              wr_err,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              word_done,
    input  logic              burst_done,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              running,
    output logic              done
);

    logic [REG_W-1:0] step_q;
    logic [REG_W-1:0] size_q;

    dst_cfg_regs #(
        .REG_W (REG_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .cfg_unlock (cfg_unlock),
        .running    (running),
        .step_q     (step_q),
        .size_q     (size_q),
        .cfg_rdata  (cfg_rdata),
        .wr_err     (wr_err)
    );

    dst_addr_gen #(
        .REG_W    (REG_W),
        .ADDR_W   (ADDR_W),
        .STEP_MAX (STEP_MAX),
        .STEP_MIN (STEP_MIN)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .base_addr (base_addr),
        .word_done (word_done),
        .running   (running),
        .step_q    (step_q),
        .dst_addr  (dst_addr)
    );

    dst_burst_ctr #(
        .REG_W (REG_W)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .burst_done (burst_done),
        .size_q     (size_q),
        .running    (running),
        .done       (done)
    );

endmodule

// File: tb/dma_dst_stepper_tb_top.sv
// Directed bench for dma_dst_stepper. Inputs change on falling edges and
// results are sampled on the falling edge after the rising edge that acts.
module dma_dst_stepper_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        cfg_unlock = 1'b0;
    logic [15:0] cfg_rdata;
    logic        wr_err;
    logic        start = 1'b0;
    logic [21:0] base_addr = '0;
    logic        word_done = 1'b0;
    logic        burst_done = 1'b0;
    logic [21:0] dst_addr;
    logic        running;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    dma_dst_stepper dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .cfg_unlock (cfg_unlock),
        .cfg_rdata  (cfg_rdata),
        .wr_err     (wr_err),
        .start      (start),
        .base_addr  (base_addr),
        .word_done  (word_done),
        .burst_done (burst_done),
        .dst_addr   (dst_addr),
        .running    (running),
        .done       (done)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Each helper starts at a falling edge and returns at the next one
    task automatic wr(input logic sel, input logic [15:0] d, input logic unl);
        cfg_sel = sel; cfg_wdata = d; cfg_unlock = unl; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_unlock = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [15:0] v);
        cfg_sel = sel;
        #1;
        v = cfg_rdata;
    endtask

    task automatic go(input logic [21:0] b);
        start = 1'b1; base_addr = b;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic strobe(input logic w, input logic b);
        word_done = w; burst_done = b;
        @(negedge clk);
        word_done = 1'b0; burst_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(1'b0, v); chk("R1", "step after reset", 32'(v), 32'h0);
        rd(1'b1, v); chk("R1", "size after reset", 32'(v), 32'h0);
        chk("R1", "running", 32'(running), 0);
        chk("R1", "done", 32'(done), 0);
        chk("R1", "wr_err", 32'(wr_err), 0);
        chk("R1", "dst_addr", 32'(dst_addr), 0);
    endtask

    task automatic t_write_and_lock();
        logic [15:0] v;
        wr(1'b0, 16'h0003, 1'b1);
        chk("R2", "wr_err on good write", 32'(wr_err), 0);
        rd(1'b0, v); chk("R2", "step readback", 32'(v), 32'h3);
        wr(1'b1, 16'h0002, 1'b1);
        rd(1'b1, v); chk("R2", "size readback", 32'(v), 32'h2);
        wr(1'b0, 16'h00AA, 1'b0);
        chk("R3", "wr_err on locked write", 32'(wr_err), 1);
        rd(1'b0, v); chk("R3", "step unchanged", 32'(v), 32'h3);
        @(negedge clk);
        chk("R3", "wr_err one cycle", 32'(wr_err), 0);
    endtask

    task automatic t_run_positive();
        logic [15:0] v;
        go(22'h000100);
        chk("R5", "running after start", 32'(running), 1);
        chk("R5", "base loaded", 32'(dst_addr), 32'h100);
        go(22'h002000);
        chk("R5", "restart ignored", 32'(dst_addr), 32'h100);
        strobe(1'b1, 1'b0); chk("R6", "step +3 first", 32'(dst_addr), 32'h103);
        strobe(1'b1, 1'b0); chk("R6", "step +3 second", 32'(dst_addr), 32'h106);
        strobe(1'b0, 1'b0); chk("R6", "hold without strobe", 32'(dst_addr), 32'h106);
        wr(1'b1, 16'h0009, 1'b1);
        chk("R4", "wr_err while running", 32'(wr_err), 1);
        rd(1'b1, v); chk("R4", "size unchanged", 32'(v), 32'h2);
        strobe(1'b0, 1'b1); chk("R9", "running after burst 1", 32'(running), 1);
        strobe(1'b1, 1'b1); chk("R9", "running after burst 2", 32'(running), 1);
        chk("R6", "step with burst strobe", 32'(dst_addr), 32'h109);
        strobe(1'b0, 1'b1);
        chk("R9", "running cleared after burst 3", 32'(running), 0);
        chk("R9", "done raised", 32'(done), 1);
        @(negedge clk);
        chk("R9", "done one cycle", 32'(done), 0);
        strobe(1'b1, 1'b1);
        chk("R10", "addr held while stopped", 32'(dst_addr), 32'h109);
        chk("R10", "done stays low while stopped", 32'(done), 0);
        chk("R10", "running stays low", 32'(running), 0);
    endtask

    task automatic t_run_negative();
        wr(1'b0, 16'hFFFE, 1'b1);
        wr(1'b1, 16'h0000, 1'b1);
        go(22'h000005);
        strobe(1'b1, 1'b0); chk("R6", "step -2 first", 32'(dst_addr), 32'h3);
        strobe(1'b1, 1'b0); chk("R6", "step -2 second", 32'(dst_addr), 32'h1);
        strobe(1'b1, 1'b0); chk("R8", "underflow wrap", 32'(dst_addr), 32'h3FFFFF);
        strobe(1'b0, 1'b1);
        chk("R9", "size 0 ends after one burst", 32'(running), 0);
        chk("R9", "done for size 0", 32'(done), 1);
    endtask

    task automatic t_saturate_and_wrap();
        logic [15:0] v;
        wr(1'b0, 16'h7000, 1'b1);
        rd(1'b0, v); chk("R7", "illegal step stored as written", 32'(v), 32'h7000);
        go(22'h0);
        strobe(1'b1, 1'b0); chk("R7", "positive clamp", 32'(dst_addr), 32'd4095);
        strobe(1'b0, 1'b1);
        wr(1'b0, 16'h8000, 1'b1);
        go(22'h001000);
        strobe(1'b1, 1'b0); chk("R7", "negative clamp", 32'(dst_addr), 32'h0);
        strobe(1'b0, 1'b1);
        wr(1'b0, 16'h0000, 1'b1);
        go(22'h000040);
        strobe(1'b1, 1'b0); chk("R6", "zero step", 32'(dst_addr), 32'h40);
        strobe(1'b0, 1'b1);
        wr(1'b0, 16'h0001, 1'b1);
        go(22'h3FFFFF);
        strobe(1'b1, 1'b0); chk("R8", "overflow wrap", 32'(dst_addr), 32'h0);
        strobe(1'b0, 1'b1);
        chk("R9", "final run done", 32'(done), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_write_and_lock();
        t_run_positive();
        t_run_negative();
        t_saturate_and_wrap();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule